// File: doc/BRIEF.md
# Exception Vector Fetch Unit

The unit sits between a core's exception logic and a word-wide memory read port. It owns a relocatable table-base register. After reset it reads two words from the table. The word at index zero becomes the initial stack pointer. The word at index one becomes the first program counter. After that boot sequence the unit is ready. For each exception number it is handed, it reads the matching table word and delivers it as the new program counter, together with a done pulse.

Table entries are one 32-bit word each, so entry `n` lives at `base + 4*n`, taken modulo 2^32. The base register keeps its low seven bits at zero, which holds the table on a 128-byte boundary. Only one memory read is ever outstanding. The core sees whether a request can be taken through a ready output. Choosing between competing exceptions is left to the caller, and the unit serves whatever number it receives. Fetched words are treated purely as data. Bit zero of a fetched handler word is stripped from the program counter and reported on its own as a mode flag.

Top module: `vec_fetch`

## Requirements
- R1: While reset is asserted, `base_o`, `sp_o`, `pc_o`, `pc_mode_o` and all pulse outputs read zero, and `exc_rdy_o` is low.
- R2: After reset the unit issues a read of table index 0 (address `base_o`), and on its response loads `sp_o` with the returned word, pulsing `sp_load_o` for one cycle.
- R3: The boot sequence then reads index 1 (address `base_o + 4`) and loads the program counter from it, with `pc_load_o` strictly after `sp_load_o` and `done_o` staying low. `exc_rdy_o` first rises together with that `pc_load_o`.
- R4: `exc_req_i` is ignored until the boot sequence has finished: during boot only the two table reads are issued.
- R5: A write on `base_we_i` stores `base_wdata_i` with bits 6:0 forced to zero, and `base_o` shows it from the next cycle.
- R6: An accepted exception (`exc_req_i` high while `exc_rdy_o` is high) issues one read at `base_o + 4*exc_num_i` modulo 2^32, with `exc_num_i` 9 bits unsigned, on `mem_req_o`/`mem_addr_o` in the following cycle.
- R7: In the cycle after an exception's read response, `pc_load_o` and `done_o` pulse together, `pc_o` equals the returned word with bit 0 cleared, and `pc_mode_o` equals bit 0 of that word.
- R8: At most one read is outstanding. `exc_rdy_o` is low from the cycle after acceptance until `done_o`, and requests made in that window issue no read.
- R9: A base write made in the cycle of acceptance or during a fetch does not change that fetch's address. It applies from the next accepted fetch.
- R10: A `mem_rvalid_i` with no read outstanding is ignored: no load pulse, and `pc_o` and `sp_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception fetch request |
| exc_num_i | input | 9 | Exception number to fetch |
| exc_rdy_o | output | 1 | Unit idle and able to accept a request |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Read address, held until the next request |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| base_we_i | input | 1 | Table-base write enable |
| base_wdata_i | input | 32 | Table-base write value |
| base_o | output | 32 | Current table base, 128-byte aligned |
| sp_load_o | output | 1 | Stack-pointer load pulse |
| sp_o | output | 32 | Stack-pointer value |
| pc_load_o | output | 1 | Program-counter load pulse |
| pc_o | output | 32 | Program-counter value, bit 0 always zero |
| pc_mode_o | output | 1 | Bit 0 of the last fetched handler word |
| done_o | output | 1 | Exception fetch complete pulse |

## Verification
Several properties are checked every cycle: base alignment, an even program counter, the single outstanding read, the address issued after each acceptance, the correspondence between the response word and the loaded program counter with its mode bit, and the stack-pointer load preceding any program-counter load. Other behaviours only show up in the bench scenarios. These are the ordering and addresses of the boot reads while a request is held high, requests dropped while a fetch is in flight, base writes that land in the acceptance cycle or mid-fetch, responses that arrive with nothing pending, and address wrap past 2^32.

// File: rtl/vf_pkg.sv
package vf_pkg;
  localparam int unsigned VF_ADDR_W      = 32;
  localparam int unsigned VF_NUM_W       = 9;
  localparam int unsigned VF_ALIGN_W     = 7;
  localparam int unsigned VF_ENTRY_SHIFT = 2;

  typedef enum logic [2:0] {
    ST_BOOT    = 3'd0,
    ST_SP_WAIT = 3'd1,
    ST_PC_REQ  = 3'd2,
    ST_PC_WAIT = 3'd3,
    ST_READY   = 3'd4,
    ST_EX_WAIT = 3'd5
  } vf_state_e;
endpackage

// File: rtl/vf_base_reg.sv
module vf_base_reg #(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o
);
  localparam int unsigned HI_W = AW - ALIGN_W;

  logic [HI_W-1:0] hi_q;
  logic            unused_low;

  assign unused_low = ^wdata_i[ALIGN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_q <= '0;
    else if (we_i) hi_q <= wdata_i[AW-1:ALIGN_W];
  end

  // alignment held by storage width, not by a mask on read
  assign base_o = {hi_q, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/vf_addr_gen.sv
module vf_addr_gen #(
  parameter int unsigned AW          = 32,
  parameter int unsigned NUM_W       = 9,
  parameter int unsigned ENTRY_SHIFT = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [NUM_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] offset;

  assign offset = AW'(idx_i) << ENTRY_SHIFT;
  assign addr_o = base_i + offset;  // wraps modulo 2^AW
endmodule

// File: rtl/vf_seq.sv
module vf_seq
  import vf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NUM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_req_i,
  input  logic [NUM_W-1:0] exc_num_i,
  input  logic [AW-1:0]    fetch_addr_i,
  output logic [NUM_W-1:0] idx_o,
  input  logic             rvalid_i,
  input  logic [AW-1:0]    rdata_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             sp_load_o,
  output logic [AW-1:0]    sp_o,
  output logic             pc_load_o,
  output logic [AW-1:0]    pc_o,
  output logic             pc_mode_o,
  output logic             done_o,
  output logic             rdy_o
);
  vf_state_e     state_q, state_d;
  logic          launch, sp_hit, pc_hit, ex_hit;
  logic          req_q, sp_load_q, pc_load_q, mode_q, done_q;
  logic [AW-1:0] addr_q, sp_q, pc_q;

  always_comb begin
    idx_o = exc_num_i;
    case (state_q)
      ST_BOOT:   idx_o = '0;
      ST_PC_REQ: idx_o = NUM_W'(1);
      default:   ;
    endcase
  end

  assign launch = (state_q == ST_BOOT) || (state_q == ST_PC_REQ) ||
                  ((state_q == ST_READY) && exc_req_i);
  assign sp_hit = rvalid_i && (state_q == ST_SP_WAIT);
  assign ex_hit = rvalid_i && (state_q == ST_EX_WAIT);
  assign pc_hit = ex_hit || (rvalid_i && (state_q == ST_PC_WAIT));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOT:    state_d = ST_SP_WAIT;
      ST_SP_WAIT: if (rvalid_i) state_d = ST_PC_REQ;
      ST_PC_REQ:  state_d = ST_PC_WAIT;
      ST_PC_WAIT: if (rvalid_i) state_d = ST_READY;
      ST_READY:   if (exc_req_i) state_d = ST_EX_WAIT;
      ST_EX_WAIT: if (rvalid_i) state_d = ST_READY;
      default:    state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT;
      req_q     <= 1'b0;
      addr_q    <= '0;
      sp_load_q <= 1'b0;
      sp_q      <= '0;
      pc_load_q <= 1'b0;
      pc_q      <= '0;
      mode_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_q     <= launch;
      sp_load_q <= sp_hit;
      pc_load_q <= pc_hit;
      done_q    <= ex_hit;
      // address frozen at launch: later base writes cannot move it
      if (launch) addr_q <= fetch_addr_i;
      if (sp_hit) sp_q <= rdata_i;
      if (pc_hit) begin
        pc_q   <= {rdata_i[AW-1:1], 1'b0};
        mode_q <= rdata_i[0];
      end
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign sp_load_o  = sp_load_q;
  assign sp_o       = sp_q;
  assign pc_load_o  = pc_load_q;
  assign pc_o       = pc_q;
  assign pc_mode_o  = mode_q;
  assign done_o     = done_q;
  assign rdy_o      = (state_q == ST_READY);
endmodule

// File: rtl/vec_fetch.sv
module vec_fetch
  import vf_pkg::*;
#(
  parameter int unsigned AW          = VF_ADDR_W,
  parameter int unsigned NUM_W       = VF_NUM_W,
  parameter int unsigned ALIGN_W     = VF_ALIGN_W,
  parameter int unsigned ENTRY_SHIFT = VF_ENTRY_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_req_i,
  input  logic [NUM_W-1:0] exc_num_i,
  output logic             exc_rdy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  input  logic             base_we_i,
  input  logic [AW-1:0]    base_wdata_i,
  output logic [AW-1:0]    base_o,
  output logic             sp_load_o,
  output logic [AW-1:0]    sp_o,
  output logic             pc_load_o,
  output logic [AW-1:0]    pc_o,
  output logic             pc_mode_o,
  output logic             done_o
);
  logic [NUM_W-1:0] idx;
  logic [AW-1:0]    fetch_addr;

  vf_base_reg #(.AW(AW), .ALIGN_W(ALIGN_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .base_o  (base_o)
  );

  vf_addr_gen #(.AW(AW), .NUM_W(NUM_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
    .base_i (base_o),
    .idx_i  (idx),
    .addr_o (fetch_addr)
  );

  vf_seq #(.AW(AW), .NUM_W(NUM_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exc_req_i    (exc_req_i),
    .exc_num_i    (exc_num_i),
    .fetch_addr_i (fetch_addr),
    .idx_o        (idx),
    .rvalid_i     (mem_rvalid_i),
    .rdata_i      (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .sp_load_o    (sp_load_o),
    .sp_o         (sp_o),
    .pc_load_o    (pc_load_o),
    .pc_o         (pc_o),
    .pc_mode_o    (pc_mode_o),
    .done_o       (done_o),
    .rdy_o        (exc_rdy_o)
  );
endmodule

// File: rtl/vf_fetch_chk.sv
module vf_fetch_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NUM_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exc_req_i,
  input logic [NUM_W-1:0] exc_num_i,
  input logic             exc_rdy_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rvalid_i,
  input logic [AW-1:0]    mem_rdata_i,
  input logic [AW-1:0]    base_o,
  input logic             sp_load_o,
  input logic             pc_load_o,
  input logic [AW-1:0]    pc_o,
  input logic             pc_mode_o,
  input logic             done_o
);
  logic outst_q, sp_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q   <= 1'b0;
      sp_seen_q <= 1'b0;
    end else begin
      if (mem_req_o)         outst_q <= 1'b1;
      else if (mem_rvalid_i) outst_q <= 1'b0;
      if (sp_load_o) sp_seen_q <= 1'b1;
    end
  end

  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[6:0] == 7'd0);  // R5
  AST_PC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[0] == 1'b0);  // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);  // R8
  AST_NO_RDY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !exc_rdy_o);  // R8
  AST_ACCEPT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && exc_rdy_o) |=>
      (mem_req_o && mem_addr_o == $past(base_o) + (AW'($past(exc_num_i)) << 2)));  // R6
  AST_PC_FROM_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (pc_o[AW-1:1] == $past(mem_rdata_i[AW-1:1]) &&
                   pc_mode_o == $past(mem_rdata_i[0])));  // R7
  AST_DONE_WITH_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pc_load_o);  // R7
  AST_SP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> sp_seen_q);  // R3
endmodule

bind vec_fetch vf_fetch_chk #(.AW(AW), .NUM_W(NUM_W)) u_chk (.*);

// File: tb/vec_fetch_bench.sv
module vec_fetch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [8:0]  exc_num_i = '0;
  logic        exc_rdy_o, mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0, base_o, sp_o, pc_o;
  logic        sp_load_o, pc_load_o, pc_mode_o, done_o;

  vec_fetch u_vec_fetch (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int resp_lat = 2, cnt = 0, req_cnt = 0;
  logic [31:0] pend_addr = '0, last_addr = '0, spur_data = '0;
  bit spur = 0;
  logic [31:0] cur_base = '0;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0000_00C3;
  endfunction
  function automatic logic [31:0] ent_addr(input logic [31:0] b, input logic [8:0] n);
    return b + ({23'd0, n} << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory responder
  initial forever begin
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = word_at(pend_addr); end
    end else if (spur) begin
      mem_rvalid_i = 1'b1; mem_rdata_i = spur_data; spur = 0;
    end
    if (mem_req_o) begin
      pend_addr = mem_addr_o; last_addr = mem_addr_o; cnt = resp_lat; req_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic write_base(input logic [31:0] v);
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = v;
    @(negedge clk_i);
    base_we_i = 1'b0;
    cur_base = v & 32'hFFFF_FF80;
    chk(base_o == cur_base, "R5 base write", base_o, cur_base);
  endtask

  // run one exception fetch; wr_at: 0 none, 1 same cycle as accept, 2 mid-fetch
  task automatic do_exc(input logic [8:0] n, input int lat, input int wr_at,
                        input logic [31:0] nb, input bit busy_poke);
    logic [31:0] ea, w;
    int n0, k;
    @(negedge clk_i);
    chk(exc_rdy_o == 1'b1, "R8 ready before request", {31'd0, exc_rdy_o}, 32'd1);
    ea = ent_addr(cur_base, n);
    w = word_at(ea);
    resp_lat = lat;
    n0 = req_cnt;
    exc_req_i = 1'b1; exc_num_i = n;
    if (wr_at == 1) begin base_we_i = 1'b1; base_wdata_i = nb; end
    @(negedge clk_i);
    exc_req_i = 1'b0; base_we_i = 1'b0;
    chk(exc_rdy_o == 1'b0, "R8 busy after accept", {31'd0, exc_rdy_o}, 32'd0);
    if (wr_at == 2) begin base_we_i = 1'b1; base_wdata_i = nb; end
    if (busy_poke) begin exc_req_i = 1'b1; exc_num_i = n ^ 9'h0A5; end
    k = 0;
    while (!done_o && k < 30) begin
      @(negedge clk_i);
      base_we_i = 1'b0;
      if (k == 0 && busy_poke) exc_req_i = 1'b0;
      k++;
    end
    exc_req_i = 1'b0;
    chk(done_o && pc_load_o, "R7 done and pc_load pulse", {30'd0, done_o, pc_load_o}, 32'd3);
    chk(last_addr == ea, "R6 R9 fetch address", last_addr, ea);
    chk(pc_o == {w[31:1], 1'b0}, "R7 pc value", pc_o, {w[31:1], 1'b0});
    chk(pc_mode_o == w[0], "R7 mode flag", {31'd0, pc_mode_o}, {31'd0, w[0]});
    chk(req_cnt - n0 == 1, "R8 single read per fetch", req_cnt - n0, 32'd1);
    if (wr_at != 0) cur_base = nb & 32'hFFFF_FF80;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    bit sp_seen, early_rdy;
    int k;
    logic [31:0] a0, a1, psp, ppc;
    void'($urandom(32'd4242));
    exc_req_i = 1'b1; exc_num_i = 9'd5;  // held through boot: must be ignored (R4)
    repeat (3) @(negedge clk_i);
    chk(base_o == 0 && sp_o == 0 && pc_o == 0 && !pc_mode_o, "R1 reset values", base_o | sp_o | pc_o, 32'd0);
    chk({exc_rdy_o, mem_req_o, sp_load_o, pc_load_o, done_o} == 0, "R1 reset pulses",
        {27'd0, exc_rdy_o, mem_req_o, sp_load_o, pc_load_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    sp_seen = 0; early_rdy = 0; k = 0; a0 = 'x; a1 = 'x;
    while (!pc_load_o && k < 40) begin
      @(negedge clk_i);
      if (mem_req_o && req_cnt == 1) a0 = mem_addr_o;
      if (mem_req_o && req_cnt == 2) a1 = mem_addr_o;
      if (sp_load_o) begin
        sp_seen = 1;
        chk(sp_o == word_at(32'd0), "R2 stack pointer", sp_o, word_at(32'd0));
      end
      if (exc_rdy_o && !pc_load_o) early_rdy = 1;
      k++;
    end
    exc_req_i = 1'b0;
    chk(a0 == 32'd0, "R2 first boot address", a0, 32'd0);
    chk(a1 == 32'd4, "R3 second boot address", a1, 32'd4);
    chk(sp_seen, "R3 sp before pc", {31'd0, sp_seen}, 32'd1);
    chk(pc_o == (word_at(32'd4) & 32'hFFFF_FFFE), "R3 boot pc", pc_o, word_at(32'd4) & 32'hFFFF_FFFE);
    chk(!done_o && exc_rdy_o && !early_rdy, "R3 ready with boot pc_load", {30'd0, done_o, exc_rdy_o}, 32'd1);
    chk(req_cnt == 2, "R4 requests ignored during boot", req_cnt, 32'd2);

    // R10: stray response while idle
    psp = sp_o; ppc = pc_o;
    spur_data = 32'hDEAD_BEEF; spur = 1;
    repeat (3) begin
      @(negedge clk_i);
      chk(!pc_load_o && !sp_load_o && pc_o == ppc && sp_o == psp, "R10 stray response ignored", pc_o, ppc);
    end

    write_base(32'h1234_56FF);
    do_exc(9'd0, 1, 0, '0, 0);
    do_exc(9'd511, 3, 0, '0, 0);
    do_exc(9'd17, 4, 0, '0, 1);                 // R8 request while busy
    do_exc(9'd33, 2, 1, 32'h0000_8000, 0);      // R9 write in accept cycle
    chk(base_o == 32'h0000_8000, "R9 base after same-cycle write", base_o, 32'h0000_8000);
    do_exc(9'd34, 4, 2, 32'hABCD_E07F, 0);      // R9 write mid-fetch
    do_exc(9'd34, 1, 0, '0, 0);                 // uses new base
    write_base(32'hFFFF_FFFF);
    do_exc(9'd511, 2, 0, '0, 0);                // R6 wrap past 2^32
    chk(last_addr == 32'h0000_077C, "R6 wrapped address", last_addr, 32'h0000_077C);

    for (int i = 0; i < 40; i++) begin
      if ($urandom % 4 == 0) write_base($urandom);
      do_exc(9'($urandom), 1 + int'($urandom % 4), int'($urandom % 3), $urandom, ($urandom % 5) == 0);
    end
    summary();
  end
endmodule